// File: doc/BRIEF.md
# Shared-Line Two-Level Interrupt Aggregator

This block gathers the interrupt events of a flash-card host controller and merges them with the request of a neighbouring controller onto one interrupt wire. Hardware pulses for card-detect change, status change, the three card-mode events, programmed-transfer error, buffer available and transfer done each latch into a sticky bit of a local pending register. A local mask selects which pending bits count. Their combined result feeds the global level.

The global level holds one sticky bit for this controller and one for the neighbour, whose events arrive as a single pulse input. A record mask decides whether a global bit may latch at all. A separate drive mask decides whether a latched bit raises the interrupt wire. Software reaches all five registers through a plain 32-bit write strobe with address and data. Read data follows the address combinationally.

Top module: `cfirq_ctrl`

## Requirements
- R1: After reset, all five registers read 0 and `irq_o` is low.
- R2: A pulse on `card_evt_i[k]` sets pending bit k at offset 0x004 on that clock edge, whatever the local mask holds. The implemented bits are 0 (card detect), 1 (status change), 2 (memory mode), 3 (I/O mode), 8 (IDE mode), 9 (transfer error), 10 (buffer available) and 11 (transfer done). The other positions ignore events and read 0.
- R3: Writing 1 to a bit at offset 0x004 clears it. Writing 0 leaves it unchanged.
- R4: If an event and a write-1 clear hit the same pending bit in the same cycle, the bit stays set.
- R5: The local mask at offset 0x008 stores the written value on the implemented bits (mask 0xF0F). All other bits read 0.
- R6: Global bit 0 at offset 0x800 latches one cycle after any local bit is both pending and unmasked, but only while record-mask bit 0 (offset 0x804) is 1.
- R7: A pulse on `peer_evt_i` latches global bit 1, but only while record-mask bit 1 is 1.
- R8: Writing 1 to a global bit clears it. If its source is still active in that cycle, the bit stays set.
- R9: `irq_o` is a level: high exactly when some global bit is set and the drive-mask bit at offset 0x808 for that position is 1.
- R10: The record mask and the drive mask each hold bits [1:0]. Upper bits read 0.
- R11: Reads from any other address return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| card_evt_i | input | 12 | Event pulses, one per local bit position |
| peer_evt_i | input | 1 | Event pulse from the neighbouring controller |
| irq_o | output | 1 | Shared interrupt level |

## Verification
A wrong pending or mask bit appears on the read port as soon as that register is addressed, in the cycle after the faulty edge. Through the global bit it reaches `irq_o` one cycle later. A lost set-over-clear priority shows up as a cleared bit in the very next read. A global bit that ignores its record mask raises the wire two edges after the local event. The bench model follows every register each clock, so any divergence in a visible register or on the line is reported in the cycle it first appears.

// File: rtl/cfirq_pkg.sv
package cfirq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LOC_W  = 12;
  localparam int GLB_W  = 2;

  localparam logic [LOC_W-1:0] LOC_IMPL = 12'hF0F;
  localparam logic [GLB_W-1:0] GLB_IMPL = 2'b11;

  localparam logic [ADDR_W-1:0] OFS_LPEND = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LMASK = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_GPEND = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_GREC  = 12'h804;
  localparam logic [ADDR_W-1:0] OFS_GDRV  = 12'h808;

  localparam int GIDX_SELF = 0;
  localparam int GIDX_PEER = 1;

  typedef struct packed {
    logic lpend;
    logic lmask;
    logic gpend;
    logic grec;
    logic gdrv;
  } wsel_t;
endpackage

// File: rtl/cfirq_sticky.sv
module cfirq_sticky #(
  parameter int           W    = 4,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;
  logic         upd;

  always_comb begin
    upd   = |((set_i | clr_i) & IMPL);
    q_nxt = ((q_r & ~clr_i) | set_i) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q_o = q_r;

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (IMPL[i]) begin : g_impl
      assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q_r[i]);
      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !q_r[i]);
      assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r[i] && !clr_i[i]) |=> q_r[i]);
      assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_r[i]) |-> $past(set_i[i]));
    end
  end
endmodule

// File: rtl/cfirq_local.sv
module cfirq_local #(
  parameter int           W    = 12,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         pend_wr_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o,
  output logic         any_o
);
  logic [W-1:0] mask_r, mask_nxt, clr;

  always_comb begin
    mask_nxt = wdata_i & IMPL;
    clr      = pend_wr_i ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_r <= '0;
    else if (mask_wr_i) mask_r <= mask_nxt;
  end

  cfirq_sticky #(.W(W), .IMPL(IMPL)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_i),
    .clr_i (clr),
    .q_o   (pend_o)
  );

  assign mask_o = mask_r;
  assign any_o  = |(pend_o & mask_r);

  assert_mask_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_i |=> $stable(mask_r));
endmodule

// File: rtl/cfirq_global.sv
module cfirq_global #(
  parameter int           W    = 2,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         pend_wr_i,
  input  logic         rec_wr_i,
  input  logic         drv_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] rec_o,
  output logic [W-1:0] drv_o,
  output logic         irq_o
);
  logic [W-1:0] rec_r, drv_r, rec_nxt, drv_nxt, set, clr;

  always_comb begin
    rec_nxt = wdata_i & IMPL;
    drv_nxt = wdata_i & IMPL;
    set     = src_i & rec_r;
    clr     = pend_wr_i ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rec_r <= '0;
    else if (rec_wr_i) rec_r <= rec_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        drv_r <= '0;
    else if (drv_wr_i) drv_r <= drv_nxt;
  end

  cfirq_sticky #(.W(W), .IMPL(IMPL)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set),
    .clr_i (clr),
    .q_o   (pend_o)
  );

  assign rec_o = rec_r;
  assign drv_o = drv_r;
  assign irq_o = |(pend_o & drv_r);

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_gated_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_r[i] && !pend_o[i]) |=> !pend_o[i]);
  end
endmodule

// File: rtl/cfirq_ctrl.sv
module cfirq_ctrl #(
  parameter int ADDR_W = cfirq_pkg::ADDR_W,
  parameter int DATA_W = cfirq_pkg::DATA_W,
  parameter int LOC_W  = cfirq_pkg::LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [LOC_W-1:0]  card_evt_i,
  input  logic              peer_evt_i,
  output logic              irq_o
);
  import cfirq_pkg::*;

  localparam int GW = GLB_W;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  cfirq_pkg::wsel_t wsel;
  logic [LOC_W-1:0] l_pend, l_mask;
  logic             l_any;
  logic [GW-1:0]    g_pend, g_rec, g_drv, g_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    wsel       = '0;
    wsel.lpend = bus_wr_i && (bus_addr_i == OFS_LPEND);
    wsel.lmask = bus_wr_i && (bus_addr_i == OFS_LMASK);
    wsel.gpend = bus_wr_i && (bus_addr_i == OFS_GPEND);
    wsel.grec  = bus_wr_i && (bus_addr_i == OFS_GREC);
    wsel.gdrv  = bus_wr_i && (bus_addr_i == OFS_GDRV);
  end

  cfirq_local #(.W(LOC_W), .IMPL(LOC_IMPL)) u_local (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .evt_i     (card_evt_i),
    .pend_wr_i (wsel.lpend),
    .mask_wr_i (wsel.lmask),
    .wdata_i   (bus_wdata_i[LOC_W-1:0]),
    .pend_o    (l_pend),
    .mask_o    (l_mask),
    .any_o     (l_any)
  );

  always_comb begin
    g_src            = '0;
    g_src[GIDX_SELF] = l_any;
    g_src[GIDX_PEER] = peer_evt_i;
  end

  cfirq_global #(.W(GW), .IMPL(GLB_IMPL)) u_global (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .src_i     (g_src),
    .pend_wr_i (wsel.gpend),
    .rec_wr_i  (wsel.grec),
    .drv_wr_i  (wsel.gdrv),
    .wdata_i   (bus_wdata_i[GW-1:0]),
    .pend_o    (g_pend),
    .rec_o     (g_rec),
    .drv_o     (g_drv),
    .irq_o     (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_LPEND: bus_rdata_o[LOC_W-1:0] = l_pend;
      OFS_LMASK: bus_rdata_o[LOC_W-1:0] = l_mask;
      OFS_GPEND: bus_rdata_o[GW-1:0]    = g_pend;
      OFS_GREC:  bus_rdata_o[GW-1:0]    = g_rec;
      OFS_GDRV:  bus_rdata_o[GW-1:0]    = g_drv;
      default:   bus_rdata_o = '0;
    endcase
  end

  assert_irq_from_status_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> (g_pend != '0));
  assert_local_feeds_global_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(g_pend[GIDX_SELF]) |-> $past(l_any));
  assert_peer_feeds_global_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(g_pend[GIDX_PEER]) |-> $past(peer_evt_i));
endmodule

// File: tb/cfirq_ctrl_tb_top.sv
module cfirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [11:0] card_evt;
  logic        peer_evt;
  logic        irq;

  int    errs = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 0;

  always #10 clk = ~clk;

  cfirq_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .card_evt_i  (card_evt),
    .peer_evt_i  (peer_evt),
    .irq_o       (irq)
  );

  // behavioural reference state
  int m_lp = 0, m_lm = 0, m_gp = 0, m_gr = 0, m_gd = 0;

  function automatic int m_read(input logic [11:0] a);
    case (a)
      12'h004: return m_lp;
      12'h008: return m_lm;
      12'h800: return m_gp;
      12'h804: return m_gr;
      12'h808: return m_gd;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int wd, any, nlp, ngp, src;
    if (!rst_n) begin
      m_lp = 0; m_lm = 0; m_gp = 0; m_gr = 0; m_gd = 0;
    end else begin
      wd  = int'(bus_wdata);
      any = ((m_lp & m_lm) != 0) ? 1 : 0;
      src = any + (peer_evt ? 2 : 0);
      nlp = m_lp;
      if (bus_wr && bus_addr == 12'h004) nlp = nlp & ~wd;
      nlp = (nlp | int'(card_evt)) & 'hF0F;
      ngp = m_gp;
      if (bus_wr && bus_addr == 12'h800) ngp = ngp & ~wd;
      ngp = (ngp | (src & m_gr)) & 3;
      if (bus_wr && bus_addr == 12'h008) m_lm = wd & 'hF0F;
      if (bus_wr && bus_addr == 12'h804) m_gr = wd & 3;
      if (bus_wr && bus_addr == 12'h808) m_gd = wd & 3;
      m_lp = nlp;
      m_gp = ngp;
    end
  end

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk({tag, " irq model"}, {31'b0, irq}, ((m_gp & m_gd) != 0) ? 32'd1 : 32'd0);
    chk({tag, " read model"}, bus_rdata, m_read(bus_addr));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input string t, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(t, bus_rdata, exp);
  endtask

  task automatic evt(input logic [11:0] v);
    card_evt = v;
    step();
    card_evt = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; card_evt = '0; peer_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    tag = "R1";
    rd("R1 lpend", 12'h004, 0);
    rd("R1 lmask", 12'h008, 0);
    rd("R1 gpend", 12'h800, 0);
    rd("R1 grec", 12'h804, 0);
    rd("R1 gdrv", 12'h808, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    tag = "R5";
    wr(12'h008, 32'hFFFF_FFFF);
    rd("R5 mask bits", 12'h008, 32'h0000_0F0F);
    wr(12'h008, 0);

    tag = "R2";
    evt(12'hFFF);
    rd("R2 pending latched unmasked", 12'h004, 32'h0F0F);
    step();
    rd("R2 no global with record off", 12'h800, 0);

    tag = "R3";
    wr(12'h004, 32'h00F);
    rd("R3 partial clear", 12'h004, 32'h0F00);
    wr(12'h004, 32'h000);
    rd("R3 zero write keeps", 12'h004, 32'h0F00);
    wr(12'h004, 32'hF00);
    rd("R3 full clear", 12'h004, 0);

    tag = "R4";
    card_evt = 12'h400;
    wr(12'h004, 32'h400);
    card_evt = '0;
    rd("R4 set beats clear", 12'h004, 32'h400);

    tag = "R6";
    wr(12'h008, 32'h400);
    step(); step();
    rd("R6 record off", 12'h800, 0);
    wr(12'h804, 32'h1);
    step();
    rd("R6 global self latched", 12'h800, 32'h1);
    tag = "R9";
    chk("R9 irq low with drive off", {31'b0, irq}, 0);
    wr(12'h808, 32'h1);
    chk("R9 irq high with drive on", {31'b0, irq}, 1);

    tag = "R8";
    wr(12'h800, 32'h1);
    rd("R8 source active keeps bit", 12'h800, 32'h1);
    wr(12'h004, 32'h400);
    wr(12'h800, 32'h1);
    rd("R8 cleared after source gone", 12'h800, 0);
    chk("R8 irq drops", {31'b0, irq}, 0);

    tag = "R7";
    peer_evt = 1; step(); peer_evt = 0;
    rd("R7 peer blocked by record mask", 12'h800, 0);
    wr(12'h804, 32'h3);
    peer_evt = 1; step(); peer_evt = 0;
    rd("R7 peer latched", 12'h800, 32'h2);
    chk("R9 drive bit0 only", {31'b0, irq}, 0);
    wr(12'h808, 32'h2);
    chk("R9 drive bit1", {31'b0, irq}, 1);
    wr(12'h800, 32'h2);
    rd("R8 peer cleared", 12'h800, 0);
    chk("R9 irq low after clear", {31'b0, irq}, 0);

    tag = "R10";
    wr(12'h804, 32'hFFFF_FFFF);
    rd("R10 record width", 12'h804, 32'h3);
    wr(12'h808, 32'hFFFF_FFFF);
    rd("R10 drive width", 12'h808, 32'h3);

    tag = "R11";
    wr(12'h00C, 32'hFFFF_FFFF);
    rd("R11 unmapped reads zero", 12'h00C, 0);
    rd("R11 lmask untouched", 12'h008, 32'h400);
    rd("R11 grec untouched", 12'h804, 32'h3);

    tag = "mixed R2 R3 R6 R7 R9";
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [11:0] addrs [6];
      addrs = '{12'h004, 12'h008, 12'h800, 12'h804, 12'h808, 12'h00C};
      k = int'($urandom % 6);
      card_evt = ($urandom % 4 == 0) ? 12'(1 << ($urandom % 12)) : 12'h000;
      peer_evt = ($urandom % 8 == 0);
      bus_addr = addrs[k];
      bus_wr   = ($urandom % 4 == 0);
      bus_wdata = $urandom;
      step();
    end
    card_evt = '0; peer_evt = 0; bus_wr = 0;
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule